// File: doc/BRIEF.md
# Dual-Tag Associative Cache Directory

This block is the tag store of a small fully associative cache. Each slot records a virtual page, a block number within the page, the real page that block lives in, and five state flags. The processor side searches it by virtual address. The memory-bus side searches it by real address, because the bus snoops by physical location. A third search uses the virtual page alone. It finds any slot that already holds a valid translation for that page, so a miss on a new block can reuse the real page without a map read.

Besides the searches, the directory applies flag changes by real page to every slot at once: marking a page dirty, or dropping the virtual or the real tag of every block of that page. It also accepts per-slot flag edits, writes a freshly filled slot, and keeps a round-robin pointer that names the next slot to replace. The data array and the bus sequencing sit outside this block.

A search result comes back registered, one clock after the request. The lowest-numbered matching slot is reported. Updates made in the same cycle as a search become visible only to later searches.

Top module: `dual_tag_dir`

## Requirements
- R1: After reset every slot has all flags clear, so every search misses, `vic_index` is 0 and `res_valid` is low.
- R2: A virtual search (`lk_kind` = 0) hits a slot whose virtual page and block equal the request and whose virtual-valid flag (flag bit 0) is set.
- R3: A real search (`lk_kind` = 1) hits a slot whose real page and block equal the request and whose real-valid flag (flag bit 1) is set.
- R4: A page search (`lk_kind` = 2) ignores the block and hits a slot whose virtual page matches with both flag bits 0 and 1 set. It returns that slot's real page and its page-dirty flag (flag bit 4). `lk_kind` = 3 always misses.
- R5: A request presented with `lk_valid` in one cycle produces `res_valid` high in the next cycle only. The result fields are taken from the directory contents before that clock edge.
- R6: When several slots match, the lowest index is reported. On a miss `res_hit`, `res_index`, `res_rpage` and `res_flags` are all 0.
- R7: A fill (`wr_en`) writes the tags of slot `wr_index`. It sets virtual-valid, clears cache-dirty (bit 2) and shared (bit 3), sets real-valid to `wr_xlat`, and sets page-dirty to `wr_pdirty`.
- R8: `bulk_op` = 1 sets page-dirty in every slot whose real page equals `bulk_rpage`, and leaves all other slots unchanged.
- R9: `bulk_op` = 2 clears virtual-valid, and `bulk_op` = 3 clears real-valid, in every slot whose real page equals `bulk_rpage`.
- R10: `mod_en` updates the flags of slot `mod_index` to `(flags & ~mod_clr) | mod_set`, so a bit present in both masks ends up set.
- R11: Each cycle with `vic_sel` high advances `vic_index` by one, modulo the slot count. Without `vic_sel` it holds.
- R12: Updates to one slot in the same cycle are layered in order: the bulk operation first, then the flag edit, then the fill. The bulk compare uses the slot's real page from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Search request strobe |
| lk_kind | input | 2 | 0 virtual, 1 real, 2 page, 3 none |
| lk_vpage | input | VP_W | Virtual page key |
| lk_rpage | input | RP_W | Real page key |
| lk_blk | input | BLK_W | Block key |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_hit | output | 1 | A slot matched |
| res_index | output | IDX_W | Matching slot (0 on a miss) |
| res_rpage | output | RP_W | Real page of the matching slot |
| res_pdirty | output | 1 | Page-dirty flag of the matching slot |
| res_flags | output | 5 | All flags of the matching slot |
| wr_en | input | 1 | Fill strobe |
| wr_index | input | IDX_W | Slot to fill |
| wr_vpage | input | VP_W | Virtual page for the fill |
| wr_blk | input | BLK_W | Block for the fill |
| wr_rpage | input | RP_W | Real page for the fill |
| wr_xlat | input | 1 | Translation is known good: set real-valid |
| wr_pdirty | input | 1 | Initial page-dirty value |
| mod_en | input | 1 | Per-slot flag edit strobe |
| mod_index | input | IDX_W | Slot to edit |
| mod_set | input | 5 | Flag bits to set |
| mod_clr | input | 5 | Flag bits to clear |
| bulk_op | input | 2 | 0 idle, 1 set page-dirty, 2 clear virtual-valid, 3 clear real-valid |
| bulk_rpage | input | RP_W | Real page selected by the bulk operation |
| vic_sel | input | 1 | Advance the replacement pointer |
| vic_index | output | IDX_W | Current replacement pointer |

## Verification
A search and an update of the same slot can land on one clock edge. This is the case the design must keep ordered. The bench drives a virtual search together with a fill, a flag edit and a bulk page-dirty operation, all aimed at the slot the search hits. It expects the result to carry the tags and flags from before the edge, and a second search to show the filled contents with the fill's flags winning. A separate cycle pairs a bulk clear with a flag edit on the same slot to confirm that the edit is applied after the bulk change.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

   // flag word: bit 0 is the lowest field listed last
   typedef struct packed {
      logic pdirty;   // bit 4
      logic shared;   // bit 3
      logic cdirty;   // bit 2
      logic rvalid;   // bit 1
      logic vvalid;   // bit 0
   } cdir_flags_t;

   typedef enum logic [1:0] {
      LK_VIRT = 2'd0,
      LK_REAL = 2'd1,
      LK_PAGE = 2'd2,
      LK_NONE = 2'd3
   } cdir_kind_e;

   typedef enum logic [1:0] {
      BK_IDLE   = 2'd0,
      BK_SET_PD = 2'd1,
      BK_CLR_VV = 2'd2,
      BK_CLR_RV = 2'd3
   } cdir_bulk_e;

endpackage

// File: rtl/cdir_entry.sv
module cdir_entry
   import cdir_pkg::*;
#(
   parameter int VP_W  = 16,
   parameter int RP_W  = 14,
   parameter int BLK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [VP_W-1:0]   wr_vpage,
   input  logic [BLK_W-1:0]  wr_blk,
   input  logic [RP_W-1:0]   wr_rpage,
   input  logic              wr_xlat,
   input  logic              wr_pdirty,
   input  logic              mod_sel,
   input  cdir_flags_t       mod_set,
   input  cdir_flags_t       mod_clr,
   input  cdir_bulk_e        bulk_op,
   input  logic [RP_W-1:0]   bulk_rpage,
   input  logic [VP_W-1:0]   lk_vpage,
   input  logic [RP_W-1:0]   lk_rpage,
   input  logic [BLK_W-1:0]  lk_blk,
   output logic              hit_virt,
   output logic              hit_real,
   output logic              hit_page,
   output logic [RP_W-1:0]   rpage_q,
   output cdir_flags_t       flags_q
);

   logic [VP_W-1:0]  vpage_q;
   logic [BLK_W-1:0] blk_q;
   cdir_flags_t      flags_d;
   logic             bulk_match;

   assign bulk_match = (rpage_q == bulk_rpage);

   // layered update: bulk, then edit, then fill
   always_comb begin
      flags_d = flags_q;
      if (bulk_match) begin
         case (bulk_op)
            BK_SET_PD: flags_d.pdirty = 1'b1;
            BK_CLR_VV: flags_d.vvalid = 1'b0;
            BK_CLR_RV: flags_d.rvalid = 1'b0;
            default:   flags_d = flags_q;
         endcase
      end
      if (mod_sel) begin
         flags_d = cdir_flags_t'((flags_d & ~mod_clr) | mod_set);
      end
      if (wr_sel) begin
         flags_d        = '0;
         flags_d.vvalid = 1'b1;
         flags_d.rvalid = wr_xlat;
         flags_d.pdirty = wr_pdirty;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpage_q <= '0;
         blk_q   <= '0;
         rpage_q <= '0;
         flags_q <= '0;
      end else begin
         flags_q <= flags_d;
         if (wr_sel) begin
            vpage_q <= wr_vpage;
            blk_q   <= wr_blk;
            rpage_q <= wr_rpage;
         end
      end
   end

   assign hit_virt = flags_q.vvalid && (vpage_q == lk_vpage) && (blk_q == lk_blk);
   assign hit_real = flags_q.rvalid && (rpage_q == lk_rpage) && (blk_q == lk_blk);
   assign hit_page = flags_q.vvalid && flags_q.rvalid && (vpage_q == lk_vpage);

endmodule

// File: rtl/cdir_prio.sv
module cdir_prio #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   assign any = |req;

   // scan downward so the lowest set bit is the last to write
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/cdir_rr.sv
module cdir_rr #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);

   localparam bit               POW2 = ((N & (N - 1)) == 0);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   logic [IDX_W-1:0] ptr_nx;

   generate
      if (POW2) begin : g_wrap_free
         assign ptr_nx = ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nx = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (step) ptr <= ptr_nx;
   end

endmodule

// File: rtl/dual_tag_dir.sv
module dual_tag_dir
   import cdir_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VP_W    = 16,
   parameter int RP_W    = 14,
   parameter int BLK_W   = 4,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int FL_W   = $bits(cdir_flags_t)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [1:0]        lk_kind,
   input  logic [VP_W-1:0]   lk_vpage,
   input  logic [RP_W-1:0]   lk_rpage,
   input  logic [BLK_W-1:0]  lk_blk,
   output logic              res_valid,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_index,
   output logic [RP_W-1:0]   res_rpage,
   output logic              res_pdirty,
   output logic [FL_W-1:0]   res_flags,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_index,
   input  logic [VP_W-1:0]   wr_vpage,
   input  logic [BLK_W-1:0]  wr_blk,
   input  logic [RP_W-1:0]   wr_rpage,
   input  logic              wr_xlat,
   input  logic              wr_pdirty,
   input  logic              mod_en,
   input  logic [IDX_W-1:0]  mod_index,
   input  logic [FL_W-1:0]   mod_set,
   input  logic [FL_W-1:0]   mod_clr,
   input  logic [1:0]        bulk_op,
   input  logic [RP_W-1:0]   bulk_rpage,
   input  logic              vic_sel,
   output logic [IDX_W-1:0]  vic_index
);

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("dual_tag_dir: ENTRIES must be at least 2");
      end
      if (VP_W < 1 || RP_W < 1 || BLK_W < 1) begin : g_bad_width
         $error("dual_tag_dir: tag widths must be positive");
      end
   endgenerate

   logic [ENTRIES-1:0] hv;
   logic [ENTRIES-1:0] hr;
   logic [ENTRIES-1:0] hp;
   logic [RP_W-1:0]    ent_rp [ENTRIES];
   cdir_flags_t        ent_fl [ENTRIES];

   cdir_kind_e         kind;
   cdir_bulk_e         bulk;
   logic [ENTRIES-1:0] sel_vec;
   logic               sel_any;
   logic [IDX_W-1:0]   sel_idx;

   assign kind = cdir_kind_e'(lk_kind);
   assign bulk = cdir_bulk_e'(bulk_op);

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         cdir_entry #(
            .VP_W  (VP_W),
            .RP_W  (RP_W),
            .BLK_W (BLK_W)
         ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (wr_en && (wr_index == IDX_W'(g))),
            .wr_vpage   (wr_vpage),
            .wr_blk     (wr_blk),
            .wr_rpage   (wr_rpage),
            .wr_xlat    (wr_xlat),
            .wr_pdirty  (wr_pdirty),
            .mod_sel    (mod_en && (mod_index == IDX_W'(g))),
            .mod_set    (cdir_flags_t'(mod_set)),
            .mod_clr    (cdir_flags_t'(mod_clr)),
            .bulk_op    (bulk),
            .bulk_rpage (bulk_rpage),
            .lk_vpage   (lk_vpage),
            .lk_rpage   (lk_rpage),
            .lk_blk     (lk_blk),
            .hit_virt   (hv[g]),
            .hit_real   (hr[g]),
            .hit_page   (hp[g]),
            .rpage_q    (ent_rp[g]),
            .flags_q    (ent_fl[g])
         );
      end
   endgenerate

   always_comb begin
      case (kind)
         LK_VIRT: sel_vec = hv;
         LK_REAL: sel_vec = hr;
         LK_PAGE: sel_vec = hp;
         default: sel_vec = '0;
      endcase
   end

   cdir_prio #(
      .N     (ENTRIES),
      .IDX_W (IDX_W)
   ) u_prio (
      .req (sel_vec),
      .any (sel_any),
      .idx (sel_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_index <= '0;
         res_rpage <= '0;
         res_flags <= '0;
      end else begin
         res_valid <= lk_valid;
         if (lk_valid) begin
            res_hit   <= sel_any;
            res_index <= sel_any ? sel_idx : '0;
            res_rpage <= sel_any ? ent_rp[sel_idx] : '0;
            res_flags <= sel_any ? FL_W'(ent_fl[sel_idx]) : '0;
         end
      end
   end

   assign res_pdirty = res_flags[4];

   cdir_rr #(
      .N     (ENTRIES),
      .IDX_W (IDX_W)
   ) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (vic_sel),
      .ptr   (vic_index)
   );

endmodule

// File: rtl/dual_tag_dir_chk.sv
module dual_tag_dir_chk #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3,
   parameter int RP_W    = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic [1:0]       lk_kind,
   input logic             res_valid,
   input logic             res_hit,
   input logic [IDX_W-1:0] res_index,
   input logic [RP_W-1:0]  res_rpage,
   input logic [4:0]       res_flags,
   input logic             vic_sel,
   input logic [IDX_W-1:0] vic_index
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   // R5
   res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);

   // R5
   res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid);

   // R6
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_index == '0 && res_rpage == '0 && res_flags == '0));

   // R2
   virt_hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_kind == 2'd0) |=> (!res_hit || res_flags[0]));

   // R3
   real_hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_kind == 2'd1) |=> (!res_hit || res_flags[1]));

   // R4
   page_hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_kind == 2'd2) |=> (!res_hit || res_flags[1:0] == 2'b11));

   // R4
   none_kind_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_kind == 2'd3) |=> !res_hit);

   // R11
   vic_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_sel |=> vic_index == (($past(vic_index) == LAST) ? '0 : $past(vic_index) + 1'b1));

   // R11
   vic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vic_sel |=> $stable(vic_index));

   // R11
   vic_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_index <= LAST);

endmodule

bind dual_tag_dir dual_tag_dir_chk #(
   .ENTRIES (ENTRIES),
   .IDX_W   (IDX_W),
   .RP_W    (RP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_valid  (lk_valid),
   .lk_kind   (lk_kind),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .res_index (res_index),
   .res_rpage (res_rpage),
   .res_flags (res_flags),
   .vic_sel   (vic_sel),
   .vic_index (vic_index)
);

// File: tb/dual_tag_dir_tb.sv
module dual_tag_dir_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 8;
   localparam int VW  = 16;
   localparam int RW  = 14;
   localparam int BW  = 4;
   localparam int IW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [1:0]    lk_kind = '0;
   logic [VW-1:0] lk_vpage = '0;
   logic [RW-1:0] lk_rpage = '0;
   logic [BW-1:0] lk_blk = '0;
   logic          res_valid, res_hit, res_pdirty;
   logic [IW-1:0] res_index;
   logic [RW-1:0] res_rpage;
   logic [4:0]    res_flags;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_index = '0;
   logic [VW-1:0] wr_vpage = '0;
   logic [BW-1:0] wr_blk = '0;
   logic [RW-1:0] wr_rpage = '0;
   logic          wr_xlat = 1'b0;
   logic          wr_pdirty = 1'b0;
   logic          mod_en = 1'b0;
   logic [IW-1:0] mod_index = '0;
   logic [4:0]    mod_set = '0;
   logic [4:0]    mod_clr = '0;
   logic [1:0]    bulk_op = '0;
   logic [RW-1:0] bulk_rpage = '0;
   logic          vic_sel = 1'b0;
   logic [IW-1:0] vic_index;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_tag_dir #(.ENTRIES(N), .VP_W(VW), .RP_W(RW), .BLK_W(BW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_vpage(lk_vpage),
      .lk_rpage(lk_rpage), .lk_blk(lk_blk),
      .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index),
      .res_rpage(res_rpage), .res_pdirty(res_pdirty), .res_flags(res_flags),
      .wr_en(wr_en), .wr_index(wr_index), .wr_vpage(wr_vpage), .wr_blk(wr_blk),
      .wr_rpage(wr_rpage), .wr_xlat(wr_xlat), .wr_pdirty(wr_pdirty),
      .mod_en(mod_en), .mod_index(mod_index), .mod_set(mod_set), .mod_clr(mod_clr),
      .bulk_op(bulk_op), .bulk_rpage(bulk_rpage),
      .vic_sel(vic_sel), .vic_index(vic_index)
   );

   typedef struct packed {
      logic [1:0]    kind;
      logic [VW-1:0] vp;
      logic [RW-1:0] rp;
      logic [BW-1:0] blk;
      logic          hit;
      logic [IW-1:0] idx;
      logic [RW-1:0] erp;
      logic [4:0]    efl;
   } vec_t;

   // searches after the base fills (R2 R3 R4 R6)
   localparam vec_t TBL [11] = '{
      '{2'd0, 16'h0100, 14'h0000, 4'd1, 1'b1, 3'd0, 14'h0020, 5'h03},
      '{2'd0, 16'h0100, 14'h0000, 4'd2, 1'b1, 3'd1, 14'h0020, 5'h11},
      '{2'd0, 16'h0100, 14'h0000, 4'd3, 1'b0, 3'd0, 14'h0000, 5'h00},
      '{2'd1, 16'h0000, 14'h0020, 4'd1, 1'b1, 3'd0, 14'h0020, 5'h03},
      '{2'd1, 16'h0000, 14'h0020, 4'd2, 1'b0, 3'd0, 14'h0000, 5'h00},
      '{2'd1, 16'h0000, 14'h0030, 4'd1, 1'b1, 3'd2, 14'h0030, 5'h13},
      '{2'd2, 16'h0100, 14'h0000, 4'd9, 1'b1, 3'd0, 14'h0020, 5'h03},
      '{2'd2, 16'h0200, 14'h0000, 4'd0, 1'b1, 3'd2, 14'h0030, 5'h13},
      '{2'd2, 16'h0300, 14'h0000, 4'd0, 1'b1, 3'd5, 14'h0020, 5'h03},
      '{2'd3, 16'h0100, 14'h0020, 4'd1, 1'b0, 3'd0, 14'h0000, 5'h00},
      '{2'd1, 16'h0000, 14'h0021, 4'd1, 1'b1, 3'd3, 14'h0021, 5'h03}
   };

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic drive_look(logic [1:0] k, logic [VW-1:0] vp, logic [RW-1:0] rp, logic [BW-1:0] b);
      lk_valid = 1'b1; lk_kind = k; lk_vpage = vp; lk_rpage = rp; lk_blk = b;
   endtask

   task automatic check_res(string req, logic hit, logic [IW-1:0] idx, logic [RW-1:0] erp, logic [4:0] efl);
      check(req, "res_valid", 32'(res_valid), 32'd1);
      check(req, "res_hit", 32'(res_hit), 32'(hit));
      check(req, "res_index", 32'(res_index), 32'(idx));
      check(req, "res_rpage", 32'(res_rpage), 32'(erp));
      check(req, "res_flags", 32'(res_flags), 32'(efl));
      check(req, "res_pdirty", 32'(res_pdirty), 32'(efl[4]));
   endtask

   task automatic look(string req, logic [1:0] k, logic [VW-1:0] vp, logic [RW-1:0] rp,
                       logic [BW-1:0] b, logic hit, logic [IW-1:0] idx,
                       logic [RW-1:0] erp, logic [4:0] efl);
      drive_look(k, vp, rp, b);
      @(negedge clk);
      lk_valid = 1'b0;
      check_res(req, hit, idx, erp, efl);
   endtask

   task automatic fill(logic [IW-1:0] i, logic [VW-1:0] vp, logic [BW-1:0] b,
                       logic [RW-1:0] rp, logic x, logic pd);
      wr_en = 1'b1; wr_index = i; wr_vpage = vp; wr_blk = b; wr_rpage = rp;
      wr_xlat = x; wr_pdirty = pd;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bulk(logic [1:0] op, logic [RW-1:0] rp);
      bulk_op = op; bulk_rpage = rp;
      @(negedge clk);
      bulk_op = 2'd0;
   endtask

   task automatic modify(logic [IW-1:0] i, logic [4:0] s, logic [4:0] c);
      mod_en = 1'b1; mod_index = i; mod_set = s; mod_clr = c;
      @(negedge clk);
      mod_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", "res_valid", 32'(res_valid), 32'd0);
      check("R1", "vic_index", 32'(vic_index), 32'd0);
      look("R1", 2'd0, 16'h0000, 14'h0000, 4'd0, 1'b0, 3'd0, 14'h0, 5'h00);
      look("R1", 2'd2, 16'h0000, 14'h0000, 4'd0, 1'b0, 3'd0, 14'h0, 5'h00);

      // R5 result strobe lasts one cycle
      @(negedge clk);
      check("R5", "res_valid after idle", 32'(res_valid), 32'd0);

      // R7 base fills
      fill(3'd0, 16'h0100, 4'd1, 14'h0020, 1'b1, 1'b0);
      fill(3'd1, 16'h0100, 4'd2, 14'h0020, 1'b0, 1'b1);
      fill(3'd2, 16'h0200, 4'd1, 14'h0030, 1'b1, 1'b1);
      fill(3'd3, 16'h0100, 4'd1, 14'h0021, 1'b1, 1'b0);
      fill(3'd5, 16'h0300, 4'd3, 14'h0020, 1'b1, 1'b0);

      // R2 R3 R4 R6 table walk
      for (int i = 0; i < 11; i++) begin
         look("R2/R3/R4/R6 table", TBL[i].kind, TBL[i].vp, TBL[i].rp, TBL[i].blk,
              TBL[i].hit, TBL[i].idx, TBL[i].erp, TBL[i].efl);
      end

      // R8 set page-dirty for real page 0x20 only
      bulk(2'd1, 14'h0020);
      look("R8", 2'd2, 16'h0100, 14'h0, 4'd0, 1'b1, 3'd0, 14'h0020, 5'h13);
      look("R8", 2'd0, 16'h0300, 14'h0, 4'd3, 1'b1, 3'd5, 14'h0020, 5'h13);
      look("R8", 2'd1, 16'h0000, 14'h0021, 4'd1, 1'b1, 3'd3, 14'h0021, 5'h03);

      // R9 clear real-valid for page 0x20: page search falls to slot 3
      bulk(2'd3, 14'h0020);
      look("R9", 2'd2, 16'h0100, 14'h0, 4'd0, 1'b1, 3'd3, 14'h0021, 5'h03);
      // R9 clear virtual-valid for page 0x21
      bulk(2'd2, 14'h0021);
      look("R9", 2'd0, 16'h0100, 14'h0, 4'd1, 1'b1, 3'd0, 14'h0020, 5'h11);
      look("R9", 2'd1, 16'h0000, 14'h0021, 4'd1, 1'b1, 3'd3, 14'h0021, 5'h02);

      // R10 per-slot flag edits
      modify(3'd2, 5'h0C, 5'h00);
      look("R10", 2'd1, 16'h0000, 14'h0030, 4'd1, 1'b1, 3'd2, 14'h0030, 5'h1F);
      modify(3'd2, 5'h01, 5'h05);
      look("R10", 2'd1, 16'h0000, 14'h0030, 4'd1, 1'b1, 3'd2, 14'h0030, 5'h1B);

      // R7 refill clears cache-dirty and shared, real-valid follows wr_xlat
      fill(3'd2, 16'h0400, 4'd0, 14'h0040, 1'b0, 1'b0);
      look("R7", 2'd0, 16'h0400, 14'h0, 4'd0, 1'b1, 3'd2, 14'h0040, 5'h01);
      look("R7", 2'd1, 16'h0000, 14'h0040, 4'd0, 1'b0, 3'd0, 14'h0, 5'h00);

      // R12 search, bulk, edit and fill of slot 2 on one edge
      drive_look(2'd0, 16'h0400, 14'h0, 4'd0);
      bulk_op = 2'd1; bulk_rpage = 14'h0040;
      mod_en = 1'b1; mod_index = 3'd2; mod_set = 5'h08; mod_clr = 5'h00;
      wr_en = 1'b1; wr_index = 3'd2; wr_vpage = 16'h0500; wr_blk = 4'd0;
      wr_rpage = 14'h0050; wr_xlat = 1'b1; wr_pdirty = 1'b0;
      @(negedge clk);
      lk_valid = 1'b0; bulk_op = 2'd0; mod_en = 1'b0; wr_en = 1'b0;
      check_res("R12 old contents", 1'b1, 3'd2, 14'h0040, 5'h01);
      look("R12 fill wins", 2'd0, 16'h0500, 14'h0, 4'd0, 1'b1, 3'd2, 14'h0050, 5'h03);

      // R12 edit applied after bulk clear on slot 0
      bulk_op = 2'd2; bulk_rpage = 14'h0020;
      mod_en = 1'b1; mod_index = 3'd0; mod_set = 5'h01; mod_clr = 5'h00;
      @(negedge clk);
      bulk_op = 2'd0; mod_en = 1'b0;
      look("R12 edit over bulk", 2'd0, 16'h0100, 14'h0, 4'd1, 1'b1, 3'd0, 14'h0020, 5'h11);
      look("R9 bulk cleared slot 5", 2'd0, 16'h0300, 14'h0, 4'd3, 1'b0, 3'd0, 14'h0, 5'h00);

      // R11 round-robin pointer with wrap
      for (int k = 1; k <= N + 1; k++) begin
         vic_sel = 1'b1;
         @(negedge clk);
         vic_sel = 1'b0;
         check("R11", "vic_index step", 32'(vic_index), 32'(k % N));
      end
      @(negedge clk);
      check("R11", "vic_index hold", 32'(vic_index), 32'(1));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule